// File: doc/BRIEF.md
# Management-Interrupt and Clock-Stop Request Handler

This block sits on the processor side of the system bus. It takes two request pins from the platform. One is a system-management interrupt request and the other is a stop-clock request. It holds each request until the core reports an instruction boundary, and only then acts on it. A management request is answered with an active-low acknowledge. That acknowledge is timed against the end of the current bus cycle and against the write-buffer status. A stop-clock request starts a grant request toward the bus-cycle generator, and when that cycle finishes the core is halted.

Both request pins may change at any time relative to the bus clock, and an undriven pin reads high. Each pin passes through a synchronizer first. The management pin is then edge-detected and latched, so a short low pulse is not lost. The stop pin is used as a level, so it only counts while it stays low. When both are outstanding at one boundary, the management request is served first. A stop request is refused for as long as a management request is waiting or being served.

Top module: `pmr_handler`

## Requirements
- R1: Synchronous reset clears both pending requests and drives `mgmt_ack_n` high, `grant_req` low and `core_halt` low.
- R2: A high-to-low transition on `mgmt_req_n` sets a pending request that stays set after the pin returns high, until it is accepted.
- R3: A pending management request is accepted only on a clock where `insn_bound` is high. Without that strobe, `mgmt_ack_n` never asserts, even if `last_rdy` pulses.
- R4: After acceptance, the first `last_rdy` pulse arms the acknowledge. `mgmt_ack_n` goes low on the next clock edge at which `wbuf_empty_n` is low, which is one clock after `last_rdy` when the write buffer is already empty.
- R5: `mgmt_ack_n` stays low until `mgmt_exit` is sampled high, and goes high at that clock edge.
- R6: A stop request is accepted at an instruction boundary only if the synchronized `stop_req_n` is low at that edge. A low pulse that has ended before the boundary is ignored.
- R7: When both requests are outstanding at one boundary, the management request is taken. No stop request is accepted while a management request is pending, waiting for its acknowledge, or acknowledged.
- R8: An accepted stop request raises `grant_req`. It holds until `bus_done` is sampled high, and then `grant_req` drops and `core_halt` rises on the same edge.
- R9: `core_halt` stays high while the synchronized `stop_req_n` is low. It drops at the clock edge that samples it high.
- R10: Each request pin passes through SYNC_STAGES (default 2) flops. A boundary at clock edge e sees the pin value that was sampled at edge e-2, so a stop pin that goes low for the same cycle as the boundary is not honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_req_n | input | 1 | Management interrupt request pin, active low, asynchronous |
| stop_req_n | input | 1 | Stop-clock request pin, active low, asynchronous |
| insn_bound | input | 1 | Core is at an instruction boundary this clock |
| last_rdy | input | 1 | Last expected data-ready of the current bus cycle |
| wbuf_empty_n | input | 1 | Write buffers empty, active low |
| mgmt_exit | input | 1 | Core returns from the management handler |
| bus_done | input | 1 | Grant bus cycle has completed |
| mgmt_ack_n | output | 1 | Management acknowledge, active low, registered |
| grant_req | output | 1 | Request to run the grant bus cycle, registered |
| core_halt | output | 1 | Halt the core, registered |

## Verification
Some properties are checked on every clock. Acknowledge and grant may only begin after a boundary with the right request state. The acknowledge may only begin while the write buffer reads empty. The acknowledge holds until the exit strobe, and the halt holds while the stop pin stays low. Other behaviours need a scenario to show them: an edge latched across a long wait, a stop pulse that ends before the boundary, the two-edge synchronizer latency, and the ordering when both requests arrive together. The bench's reference model covers these cycle by cycle.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  typedef enum logic [1:0] {MG_IDLE, MG_WAIT, MG_ACK} mg_state_t;
  typedef enum logic [1:0] {SG_IDLE, SG_GRANT, SG_HALT} sg_state_t;
endpackage

// File: rtl/pmr_sync.sv
module pmr_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  localparam logic [WIDTH-1:0] FILL = {WIDTH{RST_VAL}};

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= FILL;
    else     chain[0] <= d_in;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= FILL;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/pmr_mgmt_path.sv
module pmr_mgmt_path
  import pmr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_n_s,
  input  logic insn_bound,
  input  logic last_rdy,
  input  logic wbuf_empty_n,
  input  logic mgmt_exit,
  output logic ack_n,
  output logic pend,
  output logic idle
);
  mg_state_t st_q, st_d;
  logic prev_n, armed_q, armed_d, pend_q, fall, accept;

  assign fall   = prev_n & ~req_n_s;
  assign accept = (st_q == MG_IDLE) & pend_q & insn_bound;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    case (st_q)
      MG_IDLE: if (accept) begin st_d = MG_WAIT; armed_d = 1'b0; end
      MG_WAIT: begin
        if (armed_q && !wbuf_empty_n) st_d = MG_ACK;
        else if (last_rdy)            armed_d = 1'b1;
      end
      MG_ACK:  if (mgmt_exit) begin st_d = MG_IDLE; armed_d = 1'b0; end
      default: st_d = MG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n  <= 1'b1;
      pend_q  <= 1'b0;
      st_q    <= MG_IDLE;
      armed_q <= 1'b0;
      ack_n   <= 1'b1;
    end else begin
      prev_n  <= req_n_s;
      if (fall)        pend_q <= 1'b1;
      else if (accept) pend_q <= 1'b0;
      st_q    <= st_d;
      armed_q <= armed_d;
      ack_n   <= (st_d != MG_ACK);
    end
  end

  assign pend = pend_q;
  assign idle = (st_q == MG_IDLE);

  // R3: leaving idle needs a boundary and a pending request
  a_r3_accept_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $fell(idle) |-> $past(insn_bound && pend));
  // R4: acknowledge only starts while the write buffer reads empty
  a_r4_ack_needs_empty: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> $past(!wbuf_empty_n));
  // R5: acknowledge holds until the exit strobe
  a_r5_ack_holds: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && !mgmt_exit) |=> !ack_n);
  // R5: exit strobe releases the acknowledge
  a_r5_ack_release: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && mgmt_exit) |=> ack_n);
endmodule

// File: rtl/pmr_stop_path.sv
module pmr_stop_path
  import pmr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_n_s,
  input  logic insn_bound,
  input  logic bus_done,
  input  logic mgmt_idle,
  input  logic mgmt_pend,
  output logic grant_req,
  output logic core_halt
);
  sg_state_t st_q, st_d;
  logic take;

  assign take = insn_bound & ~req_n_s & mgmt_idle & ~mgmt_pend;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SG_IDLE:  if (take)     st_d = SG_GRANT;
      SG_GRANT: if (bus_done) st_d = SG_HALT;
      SG_HALT:  if (req_n_s)  st_d = SG_IDLE;
      default:  st_d = SG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SG_IDLE;
      grant_req <= 1'b0;
      core_halt <= 1'b0;
    end else begin
      st_q      <= st_d;
      grant_req <= (st_d == SG_GRANT);
      core_halt <= (st_d == SG_HALT);
    end
  end

  // R6 / R7: a grant begins only at a boundary with the pin low and no management work
  a_r7_grant_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_req) |-> $past(insn_bound && !req_n_s && mgmt_idle && !mgmt_pend));
  // R8: halt follows a completed grant cycle
  a_r8_halt_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(core_halt) |-> $past(grant_req && bus_done));
  // R9: halt holds while the pin stays low
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (core_halt && !req_n_s) |=> core_halt);
endmodule

// File: rtl/pmr_handler.sv
module pmr_handler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mgmt_req_n,
  input  logic stop_req_n,
  input  logic insn_bound,
  input  logic last_rdy,
  input  logic wbuf_empty_n,
  input  logic mgmt_exit,
  input  logic bus_done,
  output logic mgmt_ack_n,
  output logic grant_req,
  output logic core_halt
);
  localparam int PINS = 2;

  logic [PINS-1:0] pins_s;
  logic mg_pend, mg_idle;

  pmr_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({stop_req_n, mgmt_req_n}),
    .q_out (pins_s)
  );

  pmr_mgmt_path u_mgmt (
    .clk          (clk),
    .rst          (rst),
    .req_n_s      (pins_s[0]),
    .insn_bound   (insn_bound),
    .last_rdy     (last_rdy),
    .wbuf_empty_n (wbuf_empty_n),
    .mgmt_exit    (mgmt_exit),
    .ack_n        (mgmt_ack_n),
    .pend         (mg_pend),
    .idle         (mg_idle)
  );

  pmr_stop_path u_stop (
    .clk        (clk),
    .rst        (rst),
    .req_n_s    (pins_s[1]),
    .insn_bound (insn_bound),
    .bus_done   (bus_done),
    .mgmt_idle  (mg_idle),
    .mgmt_pend  (mg_pend),
    .grant_req  (grant_req),
    .core_halt  (core_halt)
  );

  // R1: nothing is asserted in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (mgmt_ack_n && !grant_req && !core_halt));
endmodule

// File: tb/sim_pmr_handler.sv
module sim_pmr_handler;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mgmt_req_n = 1'b1, stop_req_n = 1'b1;
  logic insn_bound = 1'b0, last_rdy = 1'b0, wbuf_empty_n = 1'b0;
  logic mgmt_exit = 1'b0, bus_done = 1'b0;
  logic mgmt_ack_n, grant_req, core_halt;

  int checks = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pmr_handler u0 (
    .clk(clk), .rst(rst), .mgmt_req_n(mgmt_req_n), .stop_req_n(stop_req_n),
    .insn_bound(insn_bound), .last_rdy(last_rdy), .wbuf_empty_n(wbuf_empty_n),
    .mgmt_exit(mgmt_exit), .bus_done(bus_done), .mgmt_ack_n(mgmt_ack_n),
    .grant_req(grant_req), .core_halt(core_halt)
  );

  // behavioural reference: pin histories, request flags, phase numbers
  bit hm[$], hs[$];
  int m_phase = 0, s_phase = 0;
  bit m_pend = 0, m_armed = 0;
  bit e_ack_n = 1, e_grant = 0, e_halt = 0;

  always @(posedge clk) begin
    if (rst) begin
      hm = '{1, 1, 1}; hs = '{1, 1, 1};
      m_phase = 0; s_phase = 0; m_pend = 0; m_armed = 0;
    end else begin
      bit fell_seen, stop_low, take_m, take_s;
      int nm, ns;
      fell_seen = hm[2] && !hm[1];
      stop_low  = !hs[1];
      take_m = (m_phase == 0) && m_pend && insn_bound;
      take_s = (s_phase == 0) && insn_bound && stop_low && (m_phase == 0) && !m_pend;
      nm = m_phase; ns = s_phase;
      if (m_phase == 0 && take_m) begin nm = 1; m_armed = 0; end
      else if (m_phase == 1) begin
        if (m_armed && !wbuf_empty_n) nm = 2;
        else if (last_rdy) m_armed = 1;
      end else if (m_phase == 2 && mgmt_exit) nm = 0;
      if (s_phase == 0 && take_s) ns = 1;
      else if (s_phase == 1 && bus_done) ns = 2;
      else if (s_phase == 2 && !stop_low) ns = 0;
      if (fell_seen) m_pend = 1; else if (take_m) m_pend = 0;
      m_phase = nm; s_phase = ns;
      hm.push_front(mgmt_req_n); void'(hm.pop_back());
      hs.push_front(stop_req_n); void'(hs.pop_back());
    end
    e_ack_n = (m_phase != 2);
    e_grant = (s_phase == 1);
    e_halt  = (s_phase == 2);
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (mgmt_ack_n !== e_ack_n || grant_req !== e_grant || core_halt !== e_halt) begin
        bad++;
        $display("FAIL %s: ack_n/grant/halt actual=%b%b%b expected=%b%b%b at %0t",
                 cur_req, mgmt_ack_n, grant_req, core_halt, e_ack_n, e_grant, e_halt, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_bound();  insn_bound = 1; tick(1); insn_bound = 0; endtask
  task automatic pulse_rdy();    last_rdy = 1;   tick(1); last_rdy = 0;   endtask
  task automatic pulse_exit();   mgmt_exit = 1;  tick(1); mgmt_exit = 0;  endtask
  task automatic pulse_done();   bus_done = 1;   tick(1); bus_done = 0;   endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      bad++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    cur_req = "R1";
    expect_bit("R1 ack_n", mgmt_ack_n, 1'b1);
    expect_bit("R1 grant", grant_req, 1'b0);
    expect_bit("R1 halt", core_halt, 1'b0);
    rst = 0;
    tick(3);

    // R2 / R3: short pulse, long wait, ready strobe without a boundary
    cur_req = "R2";
    mgmt_req_n = 0; tick(2); mgmt_req_n = 1;
    tick(8);
    cur_req = "R3";
    pulse_rdy(); tick(4);
    expect_bit("R3 no ack before boundary", mgmt_ack_n, 1'b1);
    pulse_bound(); tick(2);
    cur_req = "R4";
    pulse_rdy(); tick(3);
    expect_bit("R2 latched edge acknowledged", mgmt_ack_n, 1'b0);
    cur_req = "R5";
    tick(5);
    expect_bit("R5 ack held", mgmt_ack_n, 1'b0);
    pulse_exit(); tick(2);
    expect_bit("R5 ack released", mgmt_ack_n, 1'b1);
    tick(3);

    // R4: write buffer not empty delays acknowledge
    cur_req = "R4";
    wbuf_empty_n = 1;
    mgmt_req_n = 0; tick(4); mgmt_req_n = 1; tick(2);
    pulse_bound(); tick(1); pulse_rdy(); tick(5);
    expect_bit("R4 ack waits for empty buffer", mgmt_ack_n, 1'b1);
    wbuf_empty_n = 0; tick(3);
    expect_bit("R4 ack after buffer empty", mgmt_ack_n, 1'b0);
    pulse_exit(); tick(3);

    // R6 / R8 / R9: held stop request
    cur_req = "R6";
    stop_req_n = 0; tick(4);
    pulse_bound(); tick(2);
    expect_bit("R6 grant raised", grant_req, 1'b1);
    cur_req = "R8";
    tick(3);
    expect_bit("R8 grant held", grant_req, 1'b1);
    pulse_done(); tick(1);
    expect_bit("R8 halt after done", core_halt, 1'b1);
    expect_bit("R8 grant dropped", grant_req, 1'b0);
    cur_req = "R9";
    tick(5);
    expect_bit("R9 halt held", core_halt, 1'b1);
    stop_req_n = 1; tick(4);
    expect_bit("R9 halt released", core_halt, 1'b0);

    // R6: pulse ended before boundary is ignored
    cur_req = "R6";
    stop_req_n = 0; tick(2); stop_req_n = 1; tick(5);
    pulse_bound(); tick(3);
    expect_bit("R6 ended pulse ignored", grant_req, 1'b0);

    // R10: pin low only in the boundary cycle is not seen
    cur_req = "R10";
    stop_req_n = 0; insn_bound = 1; tick(1); insn_bound = 0; stop_req_n = 1;
    tick(4);
    expect_bit("R10 sync latency", grant_req, 1'b0);

    // R7: both together, management first, stop refused meanwhile
    cur_req = "R7";
    mgmt_req_n = 0; stop_req_n = 0; tick(5); mgmt_req_n = 1;
    pulse_bound(); tick(2);
    expect_bit("R7 no grant while mgmt pending", grant_req, 1'b0);
    pulse_bound(); tick(1);
    pulse_rdy(); tick(2);
    expect_bit("R7 mgmt served first", mgmt_ack_n, 1'b0);
    pulse_bound(); tick(2);
    expect_bit("R7 no grant while acknowledged", grant_req, 1'b0);
    pulse_exit(); tick(2);
    pulse_bound(); tick(2);
    expect_bit("R7 grant after mgmt done", grant_req, 1'b1);
    pulse_done(); tick(2);
    stop_req_n = 1; tick(5);
    expect_bit("R9 final release", core_halt, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule